// File: doc/BRIEF.md
# Transmit Truncation Event Counter

This block keeps a running count of transmit frames that were cut short because the transmit FIFO ran dry and stayed empty. A one-cycle pulse on the event input adds one to an internal counter. The counter is 36 bits wide by default. It does not saturate: past its all-ones value it wraps back to zero.

Software reads the count through a simple 32-bit register read port that holds two word addresses. The lower address returns the least significant 32 bits. The upper address returns the remaining 4 bits, zero-extended to a full word. Reading the upper word clears the counter. The natural sequence is therefore to read the lower word first and the upper word last. Reading only the lower word leaves the count untouched. Writes to either address are accepted and discarded.

Top module: `ucnt_err_top`

## Requirements
- R1: After a synchronous reset the counter is 0, `rd_valid_o` is 0 and `rd_data_o` is 0.
- R2: Each clock cycle in which `evt_i` is high, and no clearing read occurs, increases the counter by exactly one. Cycles with `evt_i` low leave it unchanged.
- R3: A read at `BASE_ADDR` returns counter bits DATA_W-1:0. A read at `BASE_ADDR`+1 returns counter bits CNT_W-1:DATA_W in the low bits of the word, with every bit above them zero. A read at any other address returns zero and has no side effect.
- R4: A read at `BASE_ADDR`+1 sets the counter to zero after returning its value. A read at `BASE_ADDR` never changes the counter.
- R5: When `evt_i` is high in the same cycle as a clearing read, the read returns the value from before that event, and the counter holds 1 afterwards.
- R6: Read data and a one-cycle `rd_valid_o` pulse appear on the cycle after the `rd_en_i` strobe. The data reflects the counter as it stood before any event in the strobe cycle. Reads may be issued on consecutive cycles.
- R7: Write strobes, at any address and with any data, have no effect on the counter.
- R8: The counter wraps from all ones (2^36-1 at the default size) to zero on the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | One pulse per truncated frame |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe (ignored) |
| addr_i | input | ADDR_W | Word address |
| wr_data_i | input | DATA_W | Write data (ignored) |
| rd_data_o | output | DATA_W | Registered read data |
| rd_valid_o | output | 1 | High for one cycle when rd_data_o is new |

## Verification
A wrong counter state does not show at the ports until the next read. The bench therefore follows every group of events, writes or clears with a read, and every mismatch becomes visible exactly one cycle after that strobe. A clear that fails to happen, or that happens when it should not, first shows on the read after the clearing read. For that reason, each clear is followed immediately by a lower-word read. The wrap and the zero padding of the upper word are not reachable at the default width within the bench's run time. They are exercised on a second instance with a 6-bit counter and 4-bit words, where the same logic wraps after 64 events.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

  // Which counter word an address selects
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } word_sel_e;

endpackage

// File: rtl/ucnt_core.sv
module ucnt_core #(
  parameter int CNT_W = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;

  // A clear wins over the old value, but a same-cycle event still lands
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= {{(CNT_W-1){1'b0}}, inc_i};
    end else if (inc_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  // R2: one step per event
  a_r2_count_step : assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R2: no event, no change
  a_r2_count_hold : assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !clr_i) |=> $stable(cnt_q));

  // R4: a clear with no event empties the counter
  a_r4_clear_zero : assert property (@(posedge clk) disable iff (rst)
    (clr_i && !inc_i) |=> (cnt_q == '0));

  // R5: a clear with an event leaves one
  a_r5_clear_with_evt : assert property (@(posedge clk) disable iff (rst)
    (clr_i && inc_i) |=> (cnt_q == CNT_W'(1)));

  // R8: wrap from all ones
  a_r8_wrap : assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i && (&cnt_q)) |=> (cnt_q == '0));

endmodule

// File: rtl/ucnt_rdport.sv
module ucnt_rdport
  import ucnt_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 32,
  parameter int              CNT_W     = 36,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              clr_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);

  localparam int HI_W = CNT_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;
  localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(1);

  word_sel_e         sel;
  logic [DATA_W-1:0] lo_word;
  logic [DATA_W-1:0] hi_word;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if (addr_i == BASE_ADDR)     sel = SEL_LO;
    else if (addr_i == HI_ADDR)  sel = SEL_HI;
    else                         sel = SEL_NONE;
  end

  assign lo_word = cnt_i[DATA_W-1:0];

  // Zero-extend the upper slice when it is narrower than a word
  generate
    if (PAD_W > 0) begin : g_hi_pad
      assign hi_word = {{PAD_W{1'b0}}, cnt_i[CNT_W-1:DATA_W]};
    end else begin : g_hi_full
      assign hi_word = cnt_i[CNT_W-1:DATA_W];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_LO:  rd_mux = lo_word;
      SEL_HI:  rd_mux = hi_word;
      default: rd_mux = '0;
    endcase
  end

  assign clr_o = rd_en_i && (sel == SEL_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end

  // R6: strobe gives a valid pulse next cycle
  a_r6_valid_follows : assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);

  a_r6_valid_idle : assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rd_valid_o);

  // R3: an unmapped address reads zero
  a_r3_other_zero : assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && (sel == SEL_NONE)) |=> (rd_data_o == '0));

  // R3: lower word carries the counter's low bits as they stood
  a_r3_lo_value : assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && (sel == SEL_LO)) |=> (rd_data_o == $past(cnt_i[DATA_W-1:0])));

  generate
    if (PAD_W > 0) begin : g_pad_chk
      // R3: bits above the upper slice read zero
      a_r3_hi_pad_zero : assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && (sel == SEL_HI)) |=> (rd_data_o[DATA_W-1:HI_W] == '0));
    end
  endgenerate

endmodule

// File: rtl/ucnt_err_top.sv
module ucnt_err_top #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                CNT_W     = 36,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);

  logic [CNT_W-1:0] cnt;
  logic             clr;

  // Register space is read-only: the write side is absorbed here
  logic unused_wr;
  assign unused_wr = ^{wr_en_i, wr_data_i};

  ucnt_core #(
    .CNT_W (CNT_W)
  ) i_core (
    .clk   (clk),
    .rst   (rst),
    .inc_i (evt_i),
    .clr_i (clr),
    .cnt_o (cnt)
  );

  ucnt_rdport #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .BASE_ADDR (BASE_ADDR)
  ) i_rdport (
    .clk        (clk),
    .rst        (rst),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .cnt_i      (cnt),
    .clr_o      (clr),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  // R7: a write alone leaves the counter as it was
  a_r7_write_ignored : assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && !rd_en_i && !evt_i) |=> $stable(cnt));

  // R4: reading the lower word never clears
  a_r4_lo_keeps : assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && (addr_i == BASE_ADDR) && !evt_i) |=> $stable(cnt));

  // R1: reset leaves outputs quiet
  a_r1_reset_quiet : assert property (@(posedge clk)
    rst |=> (!rd_valid_o && (rd_data_o == '0) && (cnt == '0)));

endmodule

// File: tb/test_ucnt_err_top.sv
`timescale 1ns/1ps
module test_ucnt_err_top;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 36;
  localparam logic [ADDR_W-1:0] BASE = 8'h30;
  localparam logic [ADDR_W-1:0] HI   = 8'h31;

  localparam logic [3:0] S_BASE = 4'h2;
  localparam logic [3:0] S_HI   = 4'h3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              evt = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;

  logic       s_evt = 1'b0, s_rd_en = 1'b0;
  logic [3:0] s_addr = '0;
  logic [3:0] s_rd_data;
  logic       s_rd_valid;

  int chk = 0;
  int err = 0;

  logic [CNT_W-1:0]  model = '0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  ucnt_err_top #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .CNT_W (CNT_W), .BASE_ADDR (BASE)
  ) i_ucnt_err_top (
    .clk (clk), .rst (rst), .evt_i (evt), .rd_en_i (rd_en), .wr_en_i (wr_en),
    .addr_i (addr), .wr_data_i (wr_data), .rd_data_o (rd_data),
    .rd_valid_o (rd_valid)
  );

  ucnt_err_top #(
    .ADDR_W (4), .DATA_W (4), .CNT_W (6), .BASE_ADDR (S_BASE)
  ) i_ucnt_err_top_small (
    .clk (clk), .rst (rst), .evt_i (s_evt), .rd_en_i (s_rd_en), .wr_en_i (1'b0),
    .addr_i (s_addr), .wr_data_i (4'h0), .rd_data_o (s_rd_data),
    .rd_valid_o (s_rd_valid)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    chk++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Driver: called just after a falling edge; holds the strobe for one cycle
  task automatic rd(input logic [ADDR_W-1:0] a, input logic e, input string tag);
    logic [DATA_W-1:0] exp;
    rd_en = 1'b1; addr = a; evt = e;
    if (a == BASE)    exp = model[DATA_W-1:0];
    else if (a == HI) exp = DATA_W'(model[CNT_W-1:DATA_W]);
    else              exp = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    if (a == HI) model = CNT_W'(e);
    else         model = model + CNT_W'(e);
    @(negedge clk);
    rd_en = 1'b0; evt = 1'b0;
  endtask

  task automatic events(input int n);
    for (int i = 0; i < n; i++) begin
      evt = 1'b1; model = model + CNT_W'(1);
      @(negedge clk);
    end
    evt = 1'b0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compare each returned word against the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected valid", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic s_rd(input logic [3:0] a, input logic [3:0] exp, input string tag);
    s_rd_en = 1'b1; s_addr = a;
    @(negedge clk);
    s_rd_en = 1'b0;
    check({tag, " valid"}, 32'(s_rd_valid), 32'd1);
    check(tag, 32'(s_rd_data), 32'(exp));
  endtask

  task automatic s_events(input int n);
    for (int i = 0; i < n; i++) begin
      s_evt = 1'b1;
      @(negedge clk);
    end
    s_evt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    err++; chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", chk - err, chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet outputs after reset
    check("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
    check("R1 rd_data after reset", rd_data, 32'd0);
    rd(BASE, 1'b0, "R1 low word zero");
    rd(HI, 1'b0, "R1 high word zero");
    drain();

    // R2 / R3: count events, read lower word
    events(10);
    rd(BASE, 1'b0, "R2 ten events");
    drain();
    events(3); @(negedge clk); events(4);
    rd(BASE, 1'b0, "R2 gapped events");
    // R6: same-cycle event not yet visible, back-to-back reads
    rd(BASE, 1'b1, "R6 pre-event value");
    rd(BASE, 1'b0, "R6 back-to-back read");
    // R4: high read clears, low read shows zero afterwards
    rd(HI, 1'b0, "R4 high word before clear");
    rd(BASE, 1'b0, "R4 low word after clear");
    drain();

    // R7: writes ignored
    events(5);
    wr_en = 1'b1; addr = BASE; wr_data = 32'hFFFF_FFFF; @(negedge clk);
    addr = HI; wr_data = 32'h0000_000F; @(negedge clk);
    addr = 8'h00; wr_data = 32'h1234_5678; @(negedge clk);
    wr_en = 1'b0;
    rd(BASE, 1'b0, "R7 count after writes");
    drain();

    // R5: event on the clearing read
    events(3);
    rd(HI, 1'b1, "R5 clearing read value");
    rd(BASE, 1'b0, "R5 counter is one");
    // R3: unmapped address reads zero and does not clear
    rd(8'h32, 1'b0, "R3 unmapped read");
    rd(8'h2F, 1'b0, "R3 unmapped read below");
    rd(BASE, 1'b0, "R3 unmapped no clear");
    drain();

    // R3 / R8 on the narrow instance: low 4 bits, high 2 bits, wrap at 63
    s_events(63);
    s_rd(S_BASE, 4'hF, "R8 low word at all ones");
    s_events(1);
    s_rd(S_BASE, 4'h0, "R8 low word after wrap");
    s_rd(S_HI, 4'h0, "R8 high word after wrap");
    s_events(48);
    s_rd(S_HI, 4'h3, "R3 high slice zero padded");
    s_rd(S_BASE, 4'h0, "R4 narrow clear");

    drain();
    check("R6 scoreboard empty", 32'(exp_q.size()), 32'd0);
    $display("%0d/%0d checks passed", chk - err, chk);
    $finish;
  end

endmodule